// File: doc/BRIEF.md
# Flash Operation Status Reporter

This block models what a host sees on the read data path of a two-plane NOR-style flash array while an internal program or erase is running. A start pulse launches a program (one word) or a sector erase on the plane chosen by the address's top bit. A per-plane timer stands in for the internal operation and counts a configurable number of clock cycles. A small behavioural array stands in for the cells. While the timer runs, reads of that plane return a status word instead of array data. Reads of the other plane are served normally.

The status word carries a polling bit (bit 7) and a per-plane toggle bit (bit 6). A separate suspend indication marks one sector as erase-suspended. Reads of that sector return array data with bit 2 toggling on each read. A ready/busy output acts as the enable of a low-side driver. It pulls low while any plane is busy and otherwise releases the line, which the board pulls high.

Top module: `flash_status_rpt`

## Requirements
- R1: After synchronous reset, `rd_data` is 0, `ryby_pull_low` is 0, and every array word reads as all ones.
- R2: While a program runs on a plane, a read of any address in that plane returns bit 7 equal to the inverse of bit 7 of the loaded data, bit 6 as the toggle, and all other bits 0.
- R3: While a sector erase runs on a plane, a read of that plane returns 0 on bit 7, bit 6 as the toggle, and all other bits 0.
- R4: Bit 6 of the first busy read of a plane after a start is 0, and it inverts on each later read of that plane during the same operation.
- R5: Once an operation ends, reads return true array data, and a programmed word holds its old value ANDed with the loaded data.
- R6: A sector erase sets every word of the addressed sector to all ones; a sector is the top SEC_W address bits, and words of other sectors keep their values.
- R7: Reads of a plane that is not busy return array data while the other plane is busy.
- R8: `ryby_pull_low` rises on the clock edge that accepts a start and stays high for exactly PROG_CYCLES (program) or ERASE_CYCLES (erase) cycles, then releases.
- R9: A start aimed at a busy plane is ignored: it changes no array word and does not extend the running operation.
- R10: While `susp_en` is high, reads of sector `susp_sector` on a non-busy plane return array data with bit 2 replaced by a toggle. The toggle is 0 on the first such read and inverts on each later one. Lowering `susp_en` clears the toggle, and reads outside the sector are unaffected.
- R11: Both planes may run operations at once, and `ryby_pull_low` stays high until the later one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Launch an operation on the plane of `op_addr` |
| op_erase | input | 1 | 1 = sector erase, 0 = word program |
| op_addr | input | AW | Target address; the top bit selects the plane |
| op_data | input | DW | Data loaded for a program |
| susp_en | input | 1 | An erase-suspended sector exists |
| susp_sector | input | SEC_W | Number of the suspended sector |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read result, updated one edge after the strobe |
| ryby_pull_low | output | 1 | Enable of the open-drain low driver (1 = pull low) |

## Verification
A wrong plane timer shows on `ryby_pull_low` at the very edge it should rise or release. It also shows on the next read, which returns status where array data is due, or the reverse. A toggle flop that is stuck or not cleared shows within two reads of the same plane or sector, because bit 6 or bit 2 fails to alternate or starts at 1. A faulty commit into the array shows only on the first read of the affected word after the operation ends. The bench therefore reads back every programmed and erased word, and it also reads neighbouring words.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    localparam int BIT_POLL = 7;
    localparam int BIT_TOG  = 6;
    localparam int BIT_SUSP = 2;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    // Low byte of the word returned while a plane is busy.
    function automatic logic [7:0] busy_status(op_kind_e kind, logic ld_bit7, logic tog);
        logic [7:0] s;
        s           = 8'h00;
        s[BIT_POLL] = (kind == OP_ERASE) ? 1'b0 : ~ld_bit7;
        s[BIT_TOG]  = tog;
        return s;
    endfunction

endpackage

// File: rtl/fsr_plane_engine.sv
module fsr_plane_engine
    import flash_status_pkg::*;
#(
    parameter int AW           = 6,
    parameter int DW           = 16,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_erase,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_data,
    input  logic          rd_hit,
    output logic          busy,
    output op_kind_e      kind,
    output logic [AW-1:0] ld_addr,
    output logic [DW-1:0] ld_data,
    output logic          done,
    output logic          tog
);
    localparam int CNT_W = $clog2(PROG_CYCLES + ERASE_CYCLES + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            kind    <= OP_PROG;
            ld_addr <= '0;
            ld_data <= '0;
            tog     <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                cnt     <= start_erase ? ERASE_LOAD : PROG_LOAD;
                kind    <= start_erase ? OP_ERASE : OP_PROG;
                ld_addr <= start_addr;
                ld_data <= start_data;
                tog     <= 1'b0;
            end
        end else begin
            if (rd_hit)
                tog <= ~tog;
            if (cnt == '0)
                busy <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/fsr_array.sv
module fsr_array
    import flash_status_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DW     = 16,
    parameter int SEC_W  = 3,
    parameter int PLANES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [PLANES-1:0]          commit,
    input  op_kind_e                   kind    [PLANES],
    input  logic [PLANES-1:0][AW-1:0]  addr,
    input  logic [PLANES-1:0][DW-1:0]  data,
    input  logic [AW-1:0]              rd_addr,
    output logic [DW-1:0]              rd_word
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    assign rd_word = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int p = 0; p < PLANES; p++) begin
                    if (commit[p]) begin
                        if (kind[p] == OP_ERASE) begin
                            if (AW'(i) >> (AW - SEC_W) == addr[p] >> (AW - SEC_W))
                                mem[i] <= '1;
                        end else if (AW'(i) == addr[p]) begin
                            mem[i] <= mem[i] & data[p];
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/fsr_read_mux.sv
module fsr_read_mux
    import flash_status_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DW     = 16,
    parameter int SEC_W  = 3,
    parameter int PLANES = 2
) (
    input  logic [AW-1:0]      rd_addr,
    input  logic [DW-1:0]      arr_word,
    input  logic [PLANES-1:0]  busy,
    input  op_kind_e           kind [PLANES],
    input  logic [PLANES-1:0]  ld_bit7,
    input  logic [PLANES-1:0]  tog,
    input  logic               susp_en,
    input  logic [SEC_W-1:0]   susp_sector,
    input  logic               susp_tog,
    output logic [DW-1:0]      word,
    output logic               susp_hit
);
    localparam int PL_W = $clog2(PLANES);

    logic [PL_W-1:0] pl;
    logic            in_susp;

    assign pl      = rd_addr[AW-1 -: PL_W];
    assign in_susp = susp_en && (rd_addr[AW-1 -: SEC_W] == susp_sector);
    assign susp_hit = in_susp && !busy[pl];

    always_comb begin
        if (busy[pl]) begin
            word = DW'(busy_status(kind[pl], ld_bit7[pl], tog[pl]));
        end else begin
            word = arr_word;
            if (in_susp)
                word[BIT_SUSP] = susp_tog;
        end
    end

endmodule

// File: rtl/flash_status_rpt.sv
module flash_status_rpt
    import flash_status_pkg::*;
#(
    parameter int AW           = 6,
    parameter int DW           = 16,
    parameter int SEC_W        = 3,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_start,
    input  logic             op_erase,
    input  logic [AW-1:0]    op_addr,
    input  logic [DW-1:0]    op_data,
    input  logic             susp_en,
    input  logic [SEC_W-1:0] susp_sector,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             ryby_pull_low
);
    localparam int PLANES = 2;

    logic [PLANES-1:0]         plane_busy;
    logic [PLANES-1:0]         plane_done;
    logic [PLANES-1:0]         plane_tog;
    logic [PLANES-1:0]         plane_d7;
    logic [PLANES-1:0]         plane_erase;
    op_kind_e                  plane_kind [PLANES];
    logic [PLANES-1:0][AW-1:0] plane_addr;
    logic [PLANES-1:0][DW-1:0] plane_data;
    logic [DW-1:0]             arr_word;
    logic [DW-1:0]             mux_word;
    logic                      susp_hit;
    logic                      susp_tog;

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        fsr_plane_engine #(
            .AW(AW), .DW(DW),
            .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
        ) u_eng (
            .clk         (clk),
            .rst         (rst),
            .start       (op_start && (op_addr[AW-1] == 1'(p))),
            .start_erase (op_erase),
            .start_addr  (op_addr),
            .start_data  (op_data),
            .rd_hit      (rd_en && (rd_addr[AW-1] == 1'(p))),
            .busy        (plane_busy[p]),
            .kind        (plane_kind[p]),
            .ld_addr     (plane_addr[p]),
            .ld_data     (plane_data[p]),
            .done        (plane_done[p]),
            .tog         (plane_tog[p])
        );
        assign plane_d7[p]    = plane_data[p][BIT_POLL];
        assign plane_erase[p] = (plane_kind[p] == OP_ERASE);
    end

    fsr_array #(.AW(AW), .DW(DW), .SEC_W(SEC_W), .PLANES(PLANES)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .commit  (plane_done),
        .kind    (plane_kind),
        .addr    (plane_addr),
        .data    (plane_data),
        .rd_addr (rd_addr),
        .rd_word (arr_word)
    );

    fsr_read_mux #(.AW(AW), .DW(DW), .SEC_W(SEC_W), .PLANES(PLANES)) u_mux (
        .rd_addr     (rd_addr),
        .arr_word    (arr_word),
        .busy        (plane_busy),
        .kind        (plane_kind),
        .ld_bit7     (plane_d7),
        .tog         (plane_tog),
        .susp_en     (susp_en),
        .susp_sector (susp_sector),
        .susp_tog    (susp_tog),
        .word        (mux_word),
        .susp_hit    (susp_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            susp_tog <= 1'b0;
        end else begin
            if (rd_en)
                rd_data <= mux_word;
            if (!susp_en)
                susp_tog <= 1'b0;
            else if (rd_en && susp_hit)
                susp_tog <= ~susp_tog;
        end
    end

    assign ryby_pull_low = |plane_busy;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
    parameter int AW    = 6,
    parameter int DW    = 16,
    parameter int SEC_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             op_start,
    input logic [AW-1:0]    op_addr,
    input logic             susp_en,
    input logic [SEC_W-1:0] susp_sector,
    input logic             rd_en,
    input logic [AW-1:0]    rd_addr,
    input logic [DW-1:0]    rd_data,
    input logic             ryby_pull_low,
    input logic [1:0]       plane_busy,
    input logic [1:0]       plane_erase,
    input logic [1:0]       plane_d7,
    input logic [1:0][AW-1:0] plane_addr,
    input logic [DW-1:0]    arr_word
);
    localparam logic [DW-1:0] NOT_B2 = ~(DW'(1) << 2);

    a_r8_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(ryby_pull_low) |-> $past(op_start));

    a_r2_prog_poll_inverts: assert property (@(posedge clk) disable iff (rst)
        (rd_en && plane_busy[rd_addr[AW-1]] && !plane_erase[rd_addr[AW-1]])
        |=> (rd_data[7] == ~$past(plane_d7[rd_addr[AW-1]])));

    a_r3_erase_poll_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && plane_busy[rd_addr[AW-1]] && plane_erase[rd_addr[AW-1]])
        |=> (rd_data[7] == 1'b0));

    a_r9_busy_keeps_target: assert property (@(posedge clk) disable iff (rst)
        (op_start && plane_busy[op_addr[AW-1]])
        |=> $stable(plane_addr[$past(op_addr[AW-1])]));

    a_r10_susp_only_bit2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && susp_en && (rd_addr[AW-1 -: SEC_W] == susp_sector)
               && !plane_busy[rd_addr[AW-1]])
        |=> ((rd_data & NOT_B2) == ($past(arr_word) & NOT_B2)));

    a_r7_idle_plane_true_data: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !susp_en && !plane_busy[rd_addr[AW-1]])
        |=> (rd_data == $past(arr_word)));

endmodule

bind flash_status_rpt fsr_checker #(.AW(AW), .DW(DW), .SEC_W(SEC_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .op_start      (op_start),
    .op_addr       (op_addr),
    .susp_en       (susp_en),
    .susp_sector   (susp_sector),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .ryby_pull_low (ryby_pull_low),
    .plane_busy    (plane_busy),
    .plane_erase   (plane_erase),
    .plane_d7      (plane_d7),
    .plane_addr    (plane_addr),
    .arr_word      (arr_word)
);

// File: tb/flash_status_rpt_tb.sv
module flash_status_rpt_tb;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int SEC_W = 3;
    localparam int PROG = 8;
    localparam int ERASE = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_start = 1'b0, op_erase = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic [DW-1:0] op_data = '0;
    logic susp_en = 1'b0;
    logic [SEC_W-1:0] susp_sector = '0;
    logic rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic ryby_pull_low;
    logic ryby_line;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign ryby_line = ryby_pull_low ? 1'b0 : 1'b1;

    flash_status_rpt #(
        .AW(AW), .DW(DW), .SEC_W(SEC_W),
        .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)
    ) u_dut (
        .clk(clk), .rst(rst), .op_start(op_start), .op_erase(op_erase),
        .op_addr(op_addr), .op_data(op_data), .susp_en(susp_en),
        .susp_sector(susp_sector), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .ryby_pull_low(ryby_pull_low)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start_op(input logic erase, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        op_start = 1'b1; op_erase = erase; op_addr = a; op_data = d;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (ERASE + 2) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]    op;    // 0 program, 1 erase, 2 read-and-compare
        logic [AW-1:0] addr;
        logic [DW-1:0] val;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 6'h05, 16'h1234},
        '{2'd2, 6'h05, 16'h1234},
        '{2'd0, 6'h05, 16'hFF0F},
        '{2'd2, 6'h05, 16'h1204},
        '{2'd0, 6'h2A, 16'hA5A5},
        '{2'd2, 6'h2A, 16'hA5A5},
        '{2'd0, 6'h2B, 16'h0F0F},
        '{2'd2, 6'h01, 16'hFFFF},
        '{2'd1, 6'h28, 16'h0000},
        '{2'd2, 6'h2A, 16'hFFFF},
        '{2'd2, 6'h2B, 16'hFFFF},
        '{2'd2, 6'h05, 16'h1204},
        '{2'd0, 6'h07, 16'h00FF},
        '{2'd2, 6'h07, 16'h00FF}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 rd_data", rd_data, '0);
        check("R1 ryby", DW'(ryby_line), DW'(1));
        do_read(6'h3F, d);
        check("R1 array erased", d, 16'hFFFF);

        // R5 R6 table of program/erase/readback vectors
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: begin start_op(1'b0, VEC[i].addr, VEC[i].val); settle(); end
                2'd1: begin start_op(1'b1, VEC[i].addr, VEC[i].val); settle(); end
                default: begin
                    do_read(VEC[i].addr, d);
                    check((i == 9 || i == 10 || i == 11) ? "R6 erase" : "R5 readback", d, VEC[i].val);
                end
            endcase
        end

        // R2 R4 R7 program status on plane A
        start_op(1'b0, 6'h10, 16'h0080);
        do_read(6'h10, d); check("R2 R4 first poll", d, 16'h0000);
        do_read(6'h10, d); check("R4 toggle", d, 16'h0040);
        do_read(6'h12, d); check("R2 other addr same plane", d, 16'h0000);
        do_read(6'h2A, d); check("R7 idle plane", d, 16'hFFFF);
        settle();
        do_read(6'h10, d); check("R5 after program", d, 16'h0080);
        start_op(1'b0, 6'h13, 16'h0011);
        do_read(6'h13, d); check("R2 poll inverse", d, 16'h0080);
        settle();

        // R3 erase status on plane B, plane A readable
        start_op(1'b1, 6'h30, 16'h0000);
        do_read(6'h31, d); check("R3 erase poll", d, 16'h0000);
        do_read(6'h30, d); check("R3 R4 toggle", d, 16'h0040);
        do_read(6'h05, d); check("R7 during erase", d, 16'h1204);
        settle();

        // R8 ready/busy duration
        start_op(1'b0, 6'h14, 16'hFFFF);
        check("R8 low at start", DW'(ryby_line), DW'(0));
        repeat (PROG - 1) @(negedge clk);
        check("R8 low before end", DW'(ryby_line), DW'(0));
        @(negedge clk);
        check("R8 released", DW'(ryby_line), DW'(1));

        // R9 start to busy plane ignored
        start_op(1'b0, 6'h08, 16'h0F00);
        start_op(1'b0, 6'h09, 16'h0000);
        repeat (PROG - 2) @(negedge clk);
        check("R9 not extended", DW'(ryby_line), DW'(1));
        do_read(6'h09, d); check("R9 ignored write", d, 16'hFFFF);
        do_read(6'h08, d); check("R9 first op done", d, 16'h0F00);

        // R10 suspended sector toggle on bit 2
        @(negedge clk); susp_en = 1'b1; susp_sector = 3'd2;
        do_read(6'h12, d); check("R10 first", d, 16'hFFFB);
        do_read(6'h10, d); check("R10 toggled", d, 16'h0084);
        do_read(6'h20, d); check("R10 outside", d, 16'hFFFF);
        do_read(6'h12, d); check("R10 back", d, 16'hFFFB);
        do_read(6'h12, d); check("R10 again", d, 16'hFFFF);
        @(negedge clk); susp_en = 1'b0;
        @(negedge clk); susp_en = 1'b1;
        do_read(6'h10, d); check("R10 cleared", d, 16'h0080);
        @(negedge clk); susp_en = 1'b0;

        // R11 both planes busy
        start_op(1'b0, 6'h11, 16'h5555);
        start_op(1'b1, 6'h38, 16'h0000);
        repeat (PROG) @(negedge clk);
        check("R11 still low", DW'(ryby_line), DW'(0));
        do_read(6'h11, d); check("R11 plane A done", d, 16'h5555);
        settle();
        check("R11 released", DW'(ryby_line), DW'(1));
        do_read(6'h3F, d); check("R11 erase result", d, 16'hFFFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule